// File: doc/BRIEF.md
# Multi-Width Integer ALU with Status Flags

This block is a purely combinational integer arithmetic and logic unit for an execution pipeline. It takes two operands, a four-bit operation code, an operand-size select (byte, word or doubleword) and the current 32-bit flags word. From these it returns a result, a destination write enable and an updated flags word. Only the low 8, 16 or 32 bits of each operand are used, and every flag is taken from that active lane.

The flags word keeps its status bits at fixed positions, so later condition logic can decode them directly. The supported operations are:

- plain and carry-chained addition and subtraction
- compare
- increment and decrement
- two's-complement negation
- the four bitwise operations

Three flag-only commands set, clear or invert the carry bit and change nothing else. The caller puts the returned flags word back into its flags register and writes the result to the destination only when the write enable is high.

Top module: `mwalu_core`

## Requirements
- R1: The flags word holds carry at bit 0, parity at bit 2, adjust at bit 4, zero at bit 6, sign at bit 7 and overflow at bit 11. Bit 1 of the output is always 1. Every other bit is copied from the incoming flags word.
- R2: The size select is 0 for byte, 1 for word, 2 or 3 for doubleword. Result bits above the active size are 0, and operand bits above it have no effect.
- R3: Add (0) and add-with-carry (1) form a+b and a+b+carry-in. Carry is set when a carry leaves the top bit of the active size.
- R4: Subtract (2), subtract-with-borrow (3) and negate (7) form a-b, a-b-carry-in and 0-a. Carry is set when a borrow leaves the top bit of the active size.
- R5: Parity is 1 when the low byte of the result holds an even number of ones, at every size.
- R6: For arithmetic operations, adjust is set on a carry or borrow out of bit 3.
- R7: Sign equals the top bit of the result at the active size. Zero is set when the active-size result is all zeros.
- R8: Overflow is set when the signed result of an arithmetic operation does not fit in the active size.
- R9: Increment (5) and decrement (6) update overflow, sign, zero, adjust and parity, and keep the incoming carry.
- R10: Compare (4) puts a-b on the result and updates all six status flags. Its write enable is 0.
- R11: AND (8), OR (9), XOR (10) and NOT of a (11) clear carry, overflow and adjust, and set sign, zero and parity from the result.
- R12: Set-carry (12), clear-carry (13) and invert-carry (14) change only bit 0. They output a zero result with write enable 0.
- R13: Write enable is 1 for opcodes 0-3 and 5-11. Opcode 15 is a no-op: write enable 0, result 0, flags equal to the input with bit 1 forced to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a_i | input | 32 | First operand (destination value) |
| opnd_b_i | input | 32 | Second operand (source value) |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand size select |
| flags_i | input | 32 | Current flags word |
| result_o | output | 32 | Result, zero above the active size |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 32 | Updated flags word |

## Verification
There are no registers in the block, so the result, write enable and flags word are all due in the same cycle that the inputs change. The bench drives each new input set just after a rising clock edge and samples all three outputs at the following falling edge. By then the combinational paths have settled, and no output is read at an edge where the inputs are changing.

// File: rtl/mwalu_pkg.sv
// Shared definitions for the multi-width ALU: operation codes, size select,
// datapath width and the fixed bit positions of the status flags.
// Assumes a 32-bit datapath; byte and word lanes are its low 8 and 16 bits.
package mwalu_pkg;

    localparam int DW     = 32;  // datapath width
    localparam int FW     = 32;  // flags word width
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    localparam int FB_CF  = 0;
    localparam int FB_ONE = 1;
    localparam int FB_PF  = 2;
    localparam int FB_AF  = 4;
    localparam int FB_ZF  = 6;
    localparam int FB_SF  = 7;
    localparam int FB_OF  = 11;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3,
        OP_CMP = 4'd4,  OP_INC = 4'd5,  OP_DEC = 4'd6,  OP_NEG = 4'd7,
        OP_AND = 4'd8,  OP_OR  = 4'd9,  OP_XOR = 4'd10, OP_NOT = 4'd11,
        OP_STC = 4'd12, OP_CLC = 4'd13, OP_CMC = 4'd14, OP_RSV = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2, SZ_DWORD_ALT = 2'd3
    } size_e;

endpackage

// File: rtl/mwalu_addsub.sv
// Shared adder/subtractor for every arithmetic operation.
// Operands arrive already masked to the active lane. top_i is the lane
// width, and msb_i is the index of the lane's sign bit.
module mwalu_addsub
    import mwalu_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int IW     = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic              cin_i,
    input  logic              sub_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [IW-1:0]     top_i,
    input  logic [IW-1:0]     msb_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o,
    output logic              aux_o,
    output logic              ovf_o
);

    logic [DATA_W:0] wide;
    logic            xm, ym, rm;

    // One extra bit of headroom; a borrow wraps so bit top_i reads as 1.
    always_comb begin
        if (sub_i) wide = {1'b0, x_i} - {1'b0, y_i} - {{DATA_W{1'b0}}, cin_i};
        else       wide = {1'b0, x_i} + {1'b0, y_i} + {{DATA_W{1'b0}}, cin_i};
    end

    // Take carry, nibble carry and signed overflow from the lane boundaries.
    always_comb begin
        sum_o  = wide[DATA_W-1:0] & mask_i;
        cout_o = wide[top_i];
        aux_o  = x_i[4] ^ y_i[4] ^ wide[4];
        xm     = x_i[msb_i];
        ym     = y_i[msb_i];
        rm     = wide[msb_i];
        ovf_o  = sub_i ? ((xm != ym) && (rm != xm)) : ((xm == ym) && (rm != xm));
    end

endmodule

// File: rtl/mwalu_logic.sv
// Bitwise unit. It gives AND, OR, XOR of the two operands and NOT of the
// first operand. Any other opcode gives 0.
// The caller masks the output to the active lane.
module mwalu_logic
    import mwalu_pkg::*;
#(
    parameter int DATA_W = DW
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  alu_op_e           op_i,
    output logic [DATA_W-1:0] res_o
);

    // Pick the bitwise function named by the opcode.
    always_comb begin
        case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_NOT:  res_o = ~a_i;
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/mwalu_status.sv
// Computes the result-derived flags: zero, sign and low-byte parity.
// Assumes res_i is already masked to the active lane, with msb_i as its sign bit.
module mwalu_status
    import mwalu_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int IW     = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic [IW-1:0]     msb_i,
    output logic              zf_o,
    output logic              sf_o,
    output logic              pf_o
);

    // Parity looks only at the low byte, whatever the lane size.
    always_comb begin
        zf_o = (res_i == '0);
        sf_o = res_i[msb_i];
        pf_o = ~^res_i[BYTE_W-1:0];
    end

endmodule

// File: rtl/mwalu_core.sv
// Top of the multi-width ALU. It decodes the opcode and lane size, steers
// operands into the shared adder or the bitwise unit, and merges the new
// status bits into the incoming flags word.
// The block is fully combinational and holds no state.
module mwalu_core
    import mwalu_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int FLAG_W = FW,
    parameter int IW     = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] opnd_a_i,
    input  logic [DATA_W-1:0] opnd_b_i,
    input  logic [3:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic [FLAG_W-1:0] flags_o
);

    alu_op_e           op;
    size_e             sz;
    logic [IW-1:0]     top_idx, msb_idx;
    logic [DATA_W-1:0] lane_mask, a_m, b_m;
    logic [DATA_W-1:0] x, y, sum, lres, res;
    logic              cin, sub, cout, aux, ovf;
    logic              zf, sf, pf;
    logic              is_arith, is_logic, is_ccmd;

    assign op = alu_op_e'(op_i);
    assign sz = size_e'(size_i);

    // Work out the lane width, its sign bit and the lane mask from the size select.
    always_comb begin
        case (sz)
            SZ_BYTE: top_idx = IW'(BYTE_W);
            SZ_WORD: top_idx = IW'(WORD_W);
            default: top_idx = IW'(DATA_W);
        endcase
        msb_idx   = top_idx - IW'(1);
        lane_mask = (DATA_W'(1) << top_idx) - DATA_W'(1);
        a_m       = opnd_a_i & lane_mask;
        b_m       = opnd_b_i & lane_mask;
    end

    // Sort the opcode into its operation group.
    always_comb begin
        is_arith = (op_i <= 4'd7);
        is_logic = (op_i >= 4'd8) && (op_i <= 4'd11);
        is_ccmd  = (op_i >= 4'd12) && (op_i <= 4'd14);
    end

    // Steer operands, carry-in and direction into the shared adder.
    always_comb begin
        x   = a_m;
        y   = b_m;
        cin = 1'b0;
        sub = 1'b0;
        case (op)
            OP_ADC:         cin = flags_i[FB_CF];
            OP_SUB, OP_CMP: sub = 1'b1;
            OP_SBB: begin sub = 1'b1; cin = flags_i[FB_CF]; end
            OP_INC:         y = DATA_W'(1);
            OP_DEC: begin   y = DATA_W'(1); sub = 1'b1; end
            OP_NEG: begin   x = '0; y = a_m; sub = 1'b1; end
            default: ;
        endcase
    end

    mwalu_addsub #(.DATA_W(DATA_W), .IW(IW)) u_addsub (
        .x_i(x), .y_i(y), .cin_i(cin), .sub_i(sub),
        .mask_i(lane_mask), .top_i(top_idx), .msb_i(msb_idx),
        .sum_o(sum), .cout_o(cout), .aux_o(aux), .ovf_o(ovf)
    );

    mwalu_logic #(.DATA_W(DATA_W)) u_logic (
        .a_i(a_m), .b_i(b_m), .op_i(op), .res_o(lres)
    );

    // Choose the result path; flag commands and the spare opcode give 0.
    always_comb begin
        if (is_arith)      res = sum;
        else if (is_logic) res = lres & lane_mask;
        else               res = '0;
        result_o = res;
        wr_en_o  = (is_arith && (op != OP_CMP)) || is_logic;
    end

    mwalu_status #(.DATA_W(DATA_W), .IW(IW)) u_status (
        .res_i(res), .msb_i(msb_idx), .zf_o(zf), .sf_o(sf), .pf_o(pf)
    );

    // Merge the new status bits into the incoming flags word.
    always_comb begin
        flags_o         = flags_i;
        flags_o[FB_ONE] = 1'b1;
        if (is_arith || is_logic) begin
            flags_o[FB_ZF] = zf;
            flags_o[FB_SF] = sf;
            flags_o[FB_PF] = pf;
        end
        if (is_arith) begin
            flags_o[FB_AF] = aux;
            flags_o[FB_OF] = ovf;
            if ((op != OP_INC) && (op != OP_DEC)) flags_o[FB_CF] = cout;
        end
        if (is_logic) begin
            flags_o[FB_CF] = 1'b0;
            flags_o[FB_OF] = 1'b0;
            flags_o[FB_AF] = 1'b0;
        end
        case (op)
            OP_STC:  flags_o[FB_CF] = 1'b1;
            OP_CLC:  flags_o[FB_CF] = 1'b0;
            OP_CMC:  flags_o[FB_CF] = ~flags_i[FB_CF];
            default: ;
        endcase
    end

    // Output invariants, checked once the combinational logic has settled.
    always_comb begin
        AST_FLAG_ONE: assert (flags_o[FB_ONE] == 1'b1);  // R1
        AST_UPPER_CLEAR: assert ((result_o & ~lane_mask) == '0);  // R2
        if ((op == OP_INC) || (op == OP_DEC))
            AST_INCDEC_KEEPS_CF: assert (flags_o[FB_CF] == flags_i[FB_CF]);  // R9
        if (op == OP_CMP)
            AST_CMP_NO_WRITE: assert (!wr_en_o);  // R10
        if (is_logic)
            AST_LOGIC_CLEARS: assert (!flags_o[FB_CF] && !flags_o[FB_OF] && !flags_o[FB_AF]);  // R11
        if (is_ccmd)
            AST_CCMD_ISOLATED: assert (((flags_o ^ flags_i) & ~(FLAG_W'(1) | FLAG_W'(2))) == '0 && !wr_en_o);  // R12
        if (op == OP_RSV)
            AST_SPARE_NOP: assert (flags_o == (flags_i | FLAG_W'(2)) && !wr_en_o && result_o == '0);  // R13
    end

endmodule

// File: tb/mwalu_core_test.sv
// Bench for mwalu_core: directed corner cases plus seeded random stimulus,
// all checked against a reference model written independently of the RTL.
module mwalu_core_test;

    logic        clk = 1'b0;
    logic [31:0] a, b, fi;
    logic [3:0]  op;
    logic [1:0]  sz;
    logic [31:0] result;
    logic        wr_en;
    logic [31:0] fo;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done  = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    mwalu_core uut (
        .opnd_a_i(a), .opnd_b_i(b), .op_i(op), .size_i(sz),
        .flags_i(fi), .result_o(result), .wr_en_o(wr_en), .flags_o(fo)
    );

    typedef struct packed {
        logic        we;
        logic [31:0] res;
        logic [31:0] fl;
    } exp_t;

    // Reference model: works in wide signed integers, one lane width at a time.
    function automatic exp_t ref_model(logic [31:0] ia, logic [31:0] ib, logic [3:0] iop,
                                       logic [1:0] isz, logic [31:0] ifl);
        exp_t   e;
        int     w;
        longint m, ua, ub, sa, sb, ux, uy, sx, sy, c, lr, sr, r, half;
        logic   cf, of, af, s_upd, is_sub;
        w    = (isz == 2'd0) ? 8 : (isz == 2'd1) ? 16 : 32;
        m    = (64'sd1 <<< w) - 1;
        half = 64'sd1 <<< (w - 1);
        ua   = longint'({32'd0, ia}) & m;
        ub   = longint'({32'd0, ib}) & m;
        sa   = (ua >= half) ? ua - (m + 1) : ua;
        sb   = (ub >= half) ? ub - (m + 1) : ub;
        cf   = ifl[0]; of = ifl[11]; af = ifl[4];
        r    = 0; s_upd = 1'b0;
        e.we = ((iop <= 4'd3) || (iop >= 4'd5 && iop <= 4'd11));
        if (iop <= 4'd7) begin
            ux = ua; uy = ub; sx = sa; sy = sb; c = 0; is_sub = 1'b0;
            case (iop)
                4'd1: c = ifl[0] ? 1 : 0;
                4'd2, 4'd4: is_sub = 1'b1;
                4'd3: begin is_sub = 1'b1; c = ifl[0] ? 1 : 0; end
                4'd5: begin uy = 1; sy = 1; end
                4'd6: begin uy = 1; sy = 1; is_sub = 1'b1; end
                4'd7: begin ux = 0; sx = 0; uy = ua; sy = sa; is_sub = 1'b1; end
                default: ;
            endcase
            lr = is_sub ? (ux - uy - c) : (ux + uy + c);
            sr = is_sub ? (sx - sy - c) : (sx + sy + c);
            r  = lr & m;
            if (iop != 4'd5 && iop != 4'd6) cf = is_sub ? (lr < 0) : (lr > m);
            of = (sr > half - 1) || (sr < -half);
            af = (((ux ^ uy ^ r) >>> 4) & 1) != 0;
            s_upd = 1'b1;
        end else if (iop <= 4'd11) begin
            case (iop)
                4'd8:    r = ua & ub;
                4'd9:    r = ua | ub;
                4'd10:   r = ua ^ ub;
                default: r = (~ua) & m;
            endcase
            cf = 1'b0; of = 1'b0; af = 1'b0; s_upd = 1'b1;
        end else if (iop == 4'd12) cf = 1'b1;
        else if (iop == 4'd13) cf = 1'b0;
        else if (iop == 4'd14) cf = ~ifl[0];
        e.res   = 32'(r);
        e.fl    = ifl;
        e.fl[1] = 1'b1;
        e.fl[0] = cf; e.fl[11] = of; e.fl[4] = af;
        if (s_upd) begin
            e.fl[6] = (r == 0);
            e.fl[7] = ((r >>> (w - 1)) & 1) != 0;
            e.fl[2] = ($countones(e.res[7:0]) % 2) == 0;
        end
        return e;
    endfunction

    function automatic string req_of(logic [3:0] iop);
        case (iop)
            4'd0, 4'd1:       return "R3";
            4'd2, 4'd3, 4'd7: return "R4";
            4'd4:             return "R10";
            4'd5, 4'd6:       return "R9";
            4'd12, 4'd13, 4'd14: return "R12";
            4'd15:            return "R13";
            default:          return "R11";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h (op=%0d size=%0d a=%h b=%h fi=%h)",
                     req, what, act, exp, op, sz, a, b, fi);
        end
    endtask

    // Drive just after a rising edge, sample at the falling edge.
    task automatic apply(logic [31:0] ia, logic [31:0] ib, logic [3:0] iop,
                         logic [1:0] isz, logic [31:0] ifl);
        @(posedge clk);
        a = ia; b = ib; op = iop; sz = isz; fi = ifl;
        @(negedge clk);
    endtask

    // Directed case with hand-computed expectations.
    task automatic directed(string req, logic [31:0] ia, logic [31:0] ib, logic [3:0] iop,
                            logic [1:0] isz, logic [31:0] ifl,
                            logic [31:0] eres, logic ewe, logic [31:0] efl);
        apply(ia, ib, iop, isz, ifl);
        chk(req, "result", result, eres);
        chk(req, "wr_en", {31'd0, wr_en}, {31'd0, ewe});
        chk(req, "flags", fo, efl);
    endtask

    // Case checked against the reference model.
    task automatic modeled(string req, logic [31:0] ia, logic [31:0] ib, logic [3:0] iop,
                           logic [1:0] isz, logic [31:0] ifl);
        exp_t e;
        apply(ia, ib, iop, isz, ifl);
        e = ref_model(ia, ib, iop, isz, ifl);
        chk(req, "result", result, e.res);
        chk(req, "wr_en", {31'd0, wr_en}, {31'd0, e.we});
        chk(req, "flags", fo, e.fl);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog all-reqs: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned seed_use;
        a = '0; b = '0; op = '0; sz = '0; fi = '0;
        seed_use = $urandom(32'h5eed_1234);
        @(negedge clk);
        // Quiet start: all-zero inputs give a zero add (R1, R7).
        chk("R1", "initial flags", fo, 32'h46);
        chk("R7", "initial result", result, 32'h0);

        directed("R3",  32'hFF, 32'h01, 4'd0, 2'd0, 32'h0, 32'h0, 1'b1, 32'h57);
        directed("R8",  32'h7F, 32'h01, 4'd0, 2'd0, 32'h0, 32'h80, 1'b1, 32'h892);
        directed("R4",  32'h0, 32'h1, 4'd2, 2'd2, 32'h0, 32'hFFFF_FFFF, 1'b1, 32'h97);
        directed("R9",  32'hFFFF, 32'h0, 4'd5, 2'd1, 32'h1, 32'h0, 1'b1, 32'h57);
        directed("R10", 32'h1234, 32'h1234, 4'd4, 2'd1, 32'h0, 32'h0, 1'b0, 32'h46);
        directed("R12", 32'h5, 32'h6, 4'd12, 2'd2, 32'hAD4, 32'h0, 1'b0, 32'hAD7);
        directed("R12", 32'h5, 32'h6, 4'd14, 2'd2, 32'h1, 32'h0, 1'b0, 32'h2);
        directed("R11", 32'hFFFF_0000, 32'h0F0F_00FF, 4'd8, 2'd2, 32'h891, 32'h0F0F_0000, 1'b1, 32'h6);
        directed("R2",  32'h1234_5678, 32'hABCD_EF01, 4'd0, 2'd0, 32'h0, 32'h79, 1'b1, 32'h2);
        directed("R5",  32'h0103, 32'h0, 4'd10, 2'd1, 32'h0, 32'h0103, 1'b1, 32'h6);
        directed("R13", 32'h1, 32'h2, 4'd15, 2'd2, 32'hA00, 32'h0, 1'b0, 32'hA02);
        directed("R3",  32'hFFFF_FFFF, 32'h0, 4'd1, 2'd3, 32'h1, 32'h0, 1'b1, 32'h57);
        directed("R4",  32'h80, 32'h0, 4'd7, 2'd0, 32'h0, 32'h80, 1'b1, 32'h883);
        directed("R6",  32'h08, 32'h08, 4'd0, 2'd0, 32'h0, 32'h10, 1'b1, 32'h12);
        directed("R7",  32'h01, 32'h0, 4'd6, 2'd0, 32'h0, 32'h0, 1'b1, 32'h46);
        modeled("R8",  32'h8000, 32'h0001, 4'd3, 2'd1, 32'h1);
        modeled("R2",  32'hDEAD_BEEF, 32'h1234_5678, 4'd11, 2'd1, 32'h0);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] ra, rb, rf;
            logic [3:0]  rop;
            logic [1:0]  rsz;
            ra  = $urandom();
            rb  = $urandom();
            rf  = $urandom();
            rop = 4'($urandom_range(0, 15));
            rsz = 2'($urandom_range(0, 3));
            if (i % 8 == 0) rb = ra;              // equal operands
            if (i % 8 == 1) ra = 32'hFFFF_FFFF;   // all-ones lane
            if (i % 8 == 2) ra = 32'h8000_8080;   // sign-bit patterns
            modeled(req_of(rop), ra, rb, rop, rsz, rf);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule